// File: doc/BRIEF.md
# Class-D Output Stage Mode and Protection Sequencer

This block supervises a two-channel bridge-tied class-D power stage. Two synchronous control lines choose between standby, mute and play. Five fault flags come from external comparators: overvoltage, undervoltage, overcurrent, thermal warning and thermal shutdown. From the control lines and the flags the block drives four outputs:

- an enable for the power stage;
- a request that puts the bridge outputs into high impedance;
- a request that forces the modulator to 50% duty on both bridge legs;
- the sink control of an open-drain diagnostic line.

Supply faults and thermal shutdown hold the stage off only while their flag is set. Overcurrent starts a timed lockout of `retry_len` cycles. At the end of the lockout the block samples the flag once more. If the flag is clear, the stage restarts. If the flag is still set, a new lockout begins. A thermal warning keeps the stage switching but forces it silent. Every output is a register, so any change on the inputs appears at the outputs one clock later.

Top module: `amp_guard_ctrl`

## Requirements
- R1: When `ctl_awake` is 0, the outputs one cycle later are `stage_en`=0, `stage_hiz`=1, `duty_half`=0 and `diag_sink`=1, whatever the other inputs are.
- R2: When `ctl_awake`=1, `ctl_unmute`=0 and no fault or lockout is present, the outputs one cycle later are `stage_en`=1, `duty_half`=1, `stage_hiz`=0 and `diag_sink`=1.
- R3: When both control lines are 1 and no fault or lockout is present, the outputs one cycle later are `stage_en`=1, `duty_half`=0, `stage_hiz`=0 and `diag_sink`=1.
- R4: Any of `flt_ovp`, `flt_uvp` or `flt_tsd` set while awake gives, one cycle later, `stage_hiz`=1, `stage_en`=0 and `diag_sink`=0. One cycle after all three clear, the outputs show the mode the control lines request.
- R5: An overcurrent flag seen while awake and not locked out starts a lockout. During the lockout the outputs are the same as in R4. The lockout lasts exactly `retry_len` cycles, and a value of 0 counts as 1. In the last cycle of the lockout the flag is sampled: if it is set, a fresh lockout begins; if it is clear, the requested mode returns.
- R6: An overcurrent pulse that arrives during a lockout, but not in its last cycle, neither lengthens nor restarts the lockout.
- R7: `flt_twarn` alone, while awake, gives one cycle later `stage_en`=1, `duty_half`=1, `stage_hiz`=0 and `diag_sink`=0. One cycle after the flag clears, the requested mode returns.
- R8: When several conditions are present, the one that acts is chosen in this order, highest first: standby, then the supply or thermal-shutdown fault, then the overcurrent lockout, then the thermal warning, then the requested mode.
- R9: Standby cancels a running overcurrent lockout. On return to awake with the overcurrent flag clear, the requested mode appears one cycle later.
- R10: While `rst_n` is 0, each clock edge sets the standby outputs of R1 and clears the lockout.
- R11: `stage_en` and `stage_hiz` are never 1 together, and `duty_half` is 1 only while `stage_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_awake | input | 1 | 0 selects standby |
| ctl_unmute | input | 1 | 0 selects mute while awake |
| flt_ovp | input | 1 | Overvoltage flag |
| flt_uvp | input | 1 | Undervoltage flag |
| flt_ocp | input | 1 | Overcurrent flag |
| flt_twarn | input | 1 | Thermal warning flag |
| flt_tsd | input | 1 | Thermal shutdown flag |
| retry_len | input | CW | Overcurrent lockout length in cycles |
| stage_en | output | 1 | Power stage enable |
| stage_hiz | output | 1 | High-impedance request for the bridge outputs |
| duty_half | output | 1 | Forces 50% duty on both bridge legs |
| diag_sink | output | 1 | 1 pulls the open-drain diagnostic line low; 0 releases it |

## Verification
The hardest situation to reach is an overcurrent pulse that lands inside a lockout but not on its last cycle. To produce it, the stimulus drops the flag after one cycle and raises it again two cycles later. It then counts the high-impedance cycles and expects the same total as for a single pulse. A second hard case is a lockout cut short by standby. A third is the boundary case of a zero lockout length. The stimulus stacks faults of several kinds and removes them one at a time, so each priority level in turn becomes the one that acts. A behavioural model is compared against the outputs on every cycle throughout.

// File: rtl/amp_guard_ctrl.sv
module amp_guard_ctrl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_awake,
  input  logic          ctl_unmute,
  input  logic          flt_ovp,
  input  logic          flt_uvp,
  input  logic          flt_ocp,
  input  logic          flt_twarn,
  input  logic          flt_tsd,
  input  logic [CW-1:0] retry_len,
  output logic          stage_en,
  output logic          stage_hiz,
  output logic          duty_half,
  output logic          diag_sink
);

  typedef enum logic [2:0] {
    S_OFF, S_MUTE, S_PLAY, S_HARD, S_OC, S_WARN
  } mode_t;

  mode_t         mode_q, mode_d;
  logic          lock_q, lock_d;
  logic [CW-1:0] cnt_q, cnt_d;

  wire hard   = flt_ovp | flt_uvp | flt_tsd;
  wire expire = ({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, retry_len};

  always_comb begin
    lock_d = lock_q;
    cnt_d  = cnt_q;
    if (!ctl_awake) begin
      lock_d = 1'b0;
      cnt_d  = '0;
    end else if (!lock_q || expire) begin
      lock_d = flt_ocp;
      cnt_d  = '0;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (!ctl_awake)       mode_d = S_OFF;
    else if (hard)        mode_d = S_HARD;
    else if (lock_d)      mode_d = S_OC;
    else if (flt_twarn)   mode_d = S_WARN;
    else if (!ctl_unmute) mode_d = S_MUTE;
    else                  mode_d = S_PLAY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= S_OFF;
      lock_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      lock_q <= lock_d;
      cnt_q  <= cnt_d;
    end
  end

  assign stage_en  = (mode_q == S_MUTE) || (mode_q == S_PLAY) || (mode_q == S_WARN);
  assign stage_hiz = (mode_q == S_OFF)  || (mode_q == S_HARD) || (mode_q == S_OC);
  assign duty_half = (mode_q == S_MUTE) || (mode_q == S_WARN);
  assign diag_sink = !((mode_q == S_HARD) || (mode_q == S_OC) || (mode_q == S_WARN));

  p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_awake |=> stage_hiz && !stage_en && !duty_half && diag_sink);

  p_hard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_awake && hard |=> stage_hiz && !stage_en && !diag_sink);

  p_oc_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_awake && flt_ocp && !lock_q |=> stage_hiz && !diag_sink);

  p_oc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_awake && lock_q && !expire |=> lock_q && stage_hiz);

  p_warn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_awake && flt_twarn && !hard && !flt_ocp && !lock_q |=>
      stage_en && duty_half && !diag_sink);

  p_play_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_awake && ctl_unmute && !hard && !flt_ocp && !flt_twarn && !lock_q |=>
      stage_en && !duty_half && diag_sink);

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(stage_en && stage_hiz) && (!duty_half || stage_en));

endmodule

// File: tb/sim_amp_guard_ctrl.sv
module sim_amp_guard_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic awake = 1'b0, unmute = 1'b0;
  logic ovp = 1'b0, uvp = 1'b0, ocp = 1'b0, tw = 1'b0, tsd = 1'b0;
  logic [15:0] rl = 16'd5;
  logic en, hiz, half, sink;

  int checks = 0, fails = 0;
  bit cmp_on = 1'b0, done = 1'b0;
  int em = 0, ml = 0, mc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amp_guard_ctrl #(.CW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_awake(awake), .ctl_unmute(unmute),
    .flt_ovp(ovp), .flt_uvp(uvp), .flt_ocp(ocp), .flt_twarn(tw), .flt_tsd(tsd),
    .retry_len(rl), .stage_en(en), .stage_hiz(hiz), .duty_half(half), .diag_sink(sink));

  // behavioural reference: 0 off,1 mute,2 play,3 hard,4 overcurrent,5 warn
  always @(posedge clk) begin
    int nl, nc, lim;
    cmp_on = 1'b1;
    lim = (rl == 0) ? 1 : int'(rl);
    if (!rst_n) begin
      em = 0; ml = 0; mc = 0;
    end else begin
      if (!awake)          begin nl = 0; nc = 0; end
      else if (ml == 0)    begin nl = int'(ocp); nc = 0; end
      else if (mc + 1 >= lim) begin nl = int'(ocp); nc = 0; end
      else                 begin nl = 1; nc = mc + 1; end
      if (!awake)                  em = 0;
      else if (ovp || uvp || tsd)  em = 3;
      else if (nl != 0)            em = 4;
      else if (tw)                 em = 5;
      else if (!unmute)            em = 1;
      else                         em = 2;
      ml = nl; mc = nc;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      int ee, eh, ed, es, got, want;
      string tag;
      ee = (em == 1 || em == 2 || em == 5);
      eh = (em == 0 || em == 3 || em == 4);
      ed = (em == 1 || em == 5);
      es = !(em == 3 || em == 4 || em == 5);
      case (em)
        0: tag = "R1 standby";
        1: tag = "R2 mute";
        2: tag = "R3 play";
        3: tag = "R4 hard fault";
        4: tag = "R5 overcurrent";
        default: tag = "R7 thermal warning";
      endcase
      got  = {en, hiz, half, sink};
      want = {ee[0], eh[0], ed[0], es[0]};
      chk(got == want, tag, got, want);
      chk(!(en && hiz) && (!half || en), "R11 exclusive outputs", {en, hiz, half}, 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_hiz(output int n);
    n = 0;
    while (hiz && n < 200) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    cyc(3);
    chk(hiz && !en && sink && !half, "R10 reset state", {en, hiz, half, sink}, 4'b0101);
    rst_n = 1'b1;
    unmute = 1'b1; ovp = 1'b1; ocp = 1'b1; tw = 1'b1;
    cyc(3);
    chk(hiz && sink && !en, "R1 standby ignores faults", {en, hiz, sink}, 3'b011);
    ovp = 0; ocp = 0; tw = 0;
    cyc(2);
    awake = 1; unmute = 0; cyc(3);
    chk(en && half && sink, "R2 mute", {en, half, sink}, 3'b111);
    unmute = 1; cyc(3);
    chk(en && !half && !hiz, "R3 play", {en, half, hiz}, 3'b100);

    ovp = 1; cyc(1);
    chk(hiz && !sink, "R4 overvoltage", {hiz, sink}, 2'b10);
    ovp = 0; cyc(1);
    chk(en && !hiz, "R4 recovery", {en, hiz}, 2'b10);
    uvp = 1; cyc(2); uvp = 0; unmute = 0; cyc(1);
    chk(en && half, "R4 recovery to mute", {en, half}, 2'b11);
    unmute = 1; tsd = 1; cyc(3); tsd = 0; cyc(2);

    ocp = 1; cyc(1); ocp = 0;
    count_hiz(n);
    chk(n == 5, "R5 lockout length", n, 5);
    ocp = 1; cyc(1); ocp = 0; cyc(1); ocp = 1; cyc(1); ocp = 0;
    count_hiz(n);
    chk(n == 3, "R6 pulse inside lockout ignored", n + 2, 5);
    ocp = 1; cyc(7);
    chk(hiz, "R5 retry with flag present", hiz, 1);
    ocp = 0; cyc(12);
    chk(en && !hiz, "R5 restart after clear", {en, hiz}, 2'b10);

    tw = 1; cyc(2);
    chk(en && half && !sink, "R7 warning mutes", {en, half, sink}, 3'b110);
    tw = 0; cyc(1);
    chk(en && !half && sink, "R7 return to play", {en, half, sink}, 3'b101);

    tsd = 1; ocp = 1; tw = 1; cyc(1); ocp = 0;
    chk(hiz && !en, "R8 shutdown over others", {en, hiz}, 2'b01);
    tsd = 0; cyc(1);
    chk(hiz, "R8 lockout over warning", hiz, 1);
    cyc(6);
    chk(en && half && !sink, "R8 warning over play", {en, half, sink}, 3'b110);
    tw = 0; awake = 0; ovp = 1; cyc(1);
    chk(sink && hiz, "R8 standby over supply fault", {sink, hiz}, 2'b11);
    ovp = 0; awake = 1; cyc(2);

    ocp = 1; cyc(1); ocp = 0; cyc(1);
    awake = 0; cyc(1); awake = 1; cyc(1);
    chk(en && !hiz, "R9 standby cancels lockout", {en, hiz}, 2'b10);

    rl = 16'd0; ocp = 1; cyc(1); ocp = 0;
    count_hiz(n);
    chk(n == 1, "R5 zero length acts as one", n, 1);
    rl = 16'd1; ocp = 1; cyc(1); ocp = 0;
    count_hiz(n);
    chk(n == 1, "R5 length one", n, 1);

    rst_n = 0; cyc(1);
    chk(hiz && sink && !en, "R10 reset while playing", {en, hiz, sink}, 3'b011);
    rst_n = 1; cyc(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule